// File: doc/BRIEF.md
# Free-Running Counter with Compare-Clear Limit

This block is a 16-bit timebase for a group of timer channels. It counts on enable ticks from a selectable power-of-two divider of the system clock. A compare-clear limit sets the period. Two counting shapes are available. In the sawtooth shape the count rises to the limit and restarts from zero. In the triangle shape the count climbs to the limit and then descends back to zero.

Software reaches the block through a small word-wide register port with four addresses. A control byte sets the divider, the counting shape, the halt state, a one-shot software clear and whether limit writes are staged. The data word holds the live count. The limit word holds the active limit. The flag word holds two sticky event flags. A new shape and a staged limit take effect only when the counter is at zero, so a period never ends with mixed settings. The halt state is exported so that attached compare channels can stop with the counter.

Top module: `frt_timer`

## Requirements
- R1: After reset the counter is halted at 0x0000, the active limit is 0xFFFF, the flag word reads 0, and the control byte reads 0x20. Control byte fields: bit 6 stage enable, bit 5 halt, bit 4 triangle shape, bit 3 software clear, bits 2:0 divider select N.
- R2: With divider select N, the count changes at most once every 2^N system clocks. A step happens on the cycle where the low N bits of a free-running 7-bit prescaler are all ones, and a new N applies from the next cycle.
- R3: In the sawtooth shape (bit 4 active as 0), a step from a count equal to the limit gives 0x0000. Any other step adds one, wrapping from 0xFFFF to 0x0000.
- R4: In the triangle shape, a step from a count equal to the limit turns the direction down, and a step from 0x0000 forces it up. The count moves by one in the current direction.
- R5: A write to bit 4 is stored at once and reads back at once. The active shape is loaded from it only on a step taken from a count of 0x0000.
- R6: With stage enable 0, a write to the limit word (address 2) changes the active limit immediately. With stage enable 1, the value is held and becomes active only on a step taken from a count of 0x0000. Address 2 always reads the active limit.
- R7: While halt is 1 the count does not step, and the output stop_o is 1.
- R8: Writing 1 to bit 3 while the written halt bit is 0 makes the next step load 0x0000 instead of counting, with no zero event. Writing 0 to bit 3 before that step cancels it. A write of 1 with halt 1 is ignored. Bit 3 always reads 0.
- R9: A write to the data word (address 1) loads the count directly, whether running or halted. This takes priority over a step in the same cycle.
- R10: zero_o pulses for one cycle when a counting step lands on 0x0000, and match_o pulses when a step is taken from a count equal to the limit in use. Flag word (address 3) bit 0 latches zero events and bit 1 latches match events. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged.
- R11: Control bit 7 reads 0 and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 2 | Register select: 0 control, 1 data, 2 limit, 3 flags |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| cnt_o | output | 16 | Live count |
| dir_up_o | output | 1 | Current direction, 1 = up |
| stop_o | output | 1 | Halt indication for attached compare channels |
| zero_o | output | 1 | One-cycle zero event |
| match_o | output | 1 | One-cycle limit-match event |

## Verification
The assertions assume that bus_addr and bus_wdata are only meaningful while bus_we is high. They also assume that a data-word write stands apart from stepping, so only a step moves the count by one. The stimulus therefore changes all inputs half a cycle away from the sampling edge and holds each write strobe for exactly one clock. It never sends a data write that the properties would confuse with a step. Data loads are checked against the reference model, and the step-size property is gated off on those cycles.

// File: rtl/frt_pkg.sv
package frt_pkg;

  parameter int unsigned FRT_W = 16;

  typedef logic [FRT_W-1:0] frt_word_t;

  typedef enum logic {
    FRT_DIR_DN = 1'b0,
    FRT_DIR_UP = 1'b1
  } frt_dir_e;

  typedef enum logic [1:0] {
    FRT_A_CTRL  = 2'd0,
    FRT_A_DATA  = 2'd1,
    FRT_A_LIMIT = 2'd2,
    FRT_A_FLAGS = 2'd3
  } frt_addr_e;

  typedef struct packed {
    frt_word_t nxt;
    frt_dir_e  dir;
  } frt_step_t;

  // One counting step for either shape.
  function automatic frt_step_t frt_step(input frt_word_t cur,
                                         input frt_word_t lim,
                                         input logic      tri_mode,
                                         input frt_dir_e  dir_in);
    frt_step_t r;
    frt_dir_e  d;
    if (!tri_mode) begin
      r.dir = FRT_DIR_UP;
      r.nxt = (cur == lim) ? '0 : cur + frt_word_t'(1);
    end else begin
      if (cur == '0)       d = FRT_DIR_UP;
      else if (cur == lim) d = FRT_DIR_DN;
      else                 d = dir_in;
      r.dir = d;
      r.nxt = (d == FRT_DIR_UP) ? cur + frt_word_t'(1) : cur - frt_word_t'(1);
    end
    return r;
  endfunction

endpackage

// File: rtl/frt_prescaler.sv
module frt_prescaler #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned PW = (1 << SEL_W) - 1;

  logic [PW-1:0] div_q;
  logic [PW-1:0] mask;

  // mask holds N low ones for select N.
  function automatic logic [PW-1:0] low_ones(input logic [SEL_W-1:0] n);
    return ~({PW{1'b1}} << n);
  endfunction

  assign mask   = low_ones(sel_i);
  assign tick_o = ((div_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + {{(PW-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/frt_ctrl_regs.sv
module frt_ctrl_regs #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr_i,
  input  logic [6:0]       ctrl_wdata_i,
  input  logic             flag_wr_i,
  input  logic [1:0]       flag_wdata_i,
  input  logic             clr_done_i,
  input  logic             zero_pulse_i,
  input  logic             match_pulse_i,
  output logic             stage_en_o,
  output logic             halt_o,
  output logic             mode_req_o,
  output logic             clr_req_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             zero_flag_o,
  output logic             match_flag_o
);
  localparam int unsigned B_STAGE = 6;
  localparam int unsigned B_HALT  = 5;
  localparam int unsigned B_MODE  = 4;
  localparam int unsigned B_CLR   = 3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_en_o <= 1'b0;
      halt_o     <= 1'b1;
      mode_req_o <= 1'b0;
      sel_o      <= '0;
    end else if (ctrl_wr_i) begin
      stage_en_o <= ctrl_wdata_i[B_STAGE];
      halt_o     <= ctrl_wdata_i[B_HALT];
      mode_req_o <= ctrl_wdata_i[B_MODE];
      sel_o      <= ctrl_wdata_i[SEL_W-1:0];
    end
  end

  // Pending software clear: set/cancel by write, dropped once consumed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          clr_req_o <= 1'b0;
    else if (ctrl_wr_i)  clr_req_o <= ctrl_wdata_i[B_CLR] & ~ctrl_wdata_i[B_HALT];
    else if (clr_done_i) clr_req_o <= 1'b0;
  end

  // Sticky flags: write 0 clears, a new event wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_flag_o  <= 1'b0;
      match_flag_o <= 1'b0;
    end else begin
      zero_flag_o  <= (zero_flag_o  & ~(flag_wr_i & ~flag_wdata_i[0])) | zero_pulse_i;
      match_flag_o <= (match_flag_o & ~(flag_wr_i & ~flag_wdata_i[1])) | match_pulse_i;
    end
  end
endmodule

// File: rtl/frt_count_core.sv
module frt_count_core
  import frt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step_i,
  input  logic      clr_req_i,
  input  logic      mode_req_i,
  input  logic      stage_en_i,
  input  logic      lim_wr_i,
  input  logic      cnt_wr_i,
  input  frt_word_t wdata_i,
  output frt_word_t cnt_o,
  output frt_word_t lim_o,
  output frt_dir_e  dir_o,
  output logic      zero_pulse_o,
  output logic      match_pulse_o,
  output logic      clr_done_o
);
  frt_word_t lim_stage_q;
  logic      mode_act_q;
  logic      at_zero;
  logic      mode_use;
  frt_word_t lim_use;
  frt_step_t nxt;
  logic      count_step;

  assign at_zero    = (cnt_o == '0);
  assign mode_use   = at_zero ? mode_req_i : mode_act_q;
  assign lim_use    = (at_zero && stage_en_i) ? lim_stage_q : lim_o;
  assign nxt        = frt_step(cnt_o, lim_use, mode_use, dir_o);
  assign clr_done_o = step_i & clr_req_i & ~cnt_wr_i;
  assign count_step = step_i & ~clr_req_i & ~cnt_wr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o         <= '0;
      dir_o         <= FRT_DIR_UP;
      mode_act_q    <= 1'b0;
      lim_o         <= '1;
      lim_stage_q   <= '1;
      zero_pulse_o  <= 1'b0;
      match_pulse_o <= 1'b0;
    end else begin
      zero_pulse_o  <= 1'b0;
      match_pulse_o <= 1'b0;
      if (cnt_wr_i) begin
        cnt_o <= wdata_i;
      end else if (clr_done_o) begin
        cnt_o <= '0;
        dir_o <= FRT_DIR_UP;
      end else if (count_step) begin
        if (at_zero) begin
          mode_act_q <= mode_req_i;
          if (stage_en_i) lim_o <= lim_stage_q;
        end
        cnt_o         <= nxt.nxt;
        dir_o         <= nxt.dir;
        zero_pulse_o  <= (nxt.nxt == '0);
        match_pulse_o <= (cnt_o == lim_use);
      end
      if (lim_wr_i) begin
        lim_stage_q <= wdata_i;
        if (!stage_en_i) lim_o <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/frt_timer.sv
module frt_timer
  import frt_pkg::*;
#(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [FRT_W-1:0] bus_wdata,
  output logic [FRT_W-1:0] bus_rdata,
  output logic [FRT_W-1:0] cnt_o,
  output logic             dir_up_o,
  output logic             stop_o,
  output logic             zero_o,
  output logic             match_o
);
  logic             tick;
  logic             step;
  logic             ctrl_wr, flag_wr, lim_wr, cnt_wr;
  logic             stage_en, halt, mode_req, clr_req, clr_done;
  logic [SEL_W-1:0] sel;
  logic             zero_flag, match_flag;
  frt_word_t        lim;
  frt_dir_e         dir;

  assign ctrl_wr = bus_we && (bus_addr == FRT_A_CTRL);
  assign cnt_wr  = bus_we && (bus_addr == FRT_A_DATA);
  assign lim_wr  = bus_we && (bus_addr == FRT_A_LIMIT);
  assign flag_wr = bus_we && (bus_addr == FRT_A_FLAGS);
  assign step    = tick & ~halt;

  frt_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .tick_o(tick)
  );

  frt_ctrl_regs #(.SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(bus_wdata[6:0]),
    .flag_wr_i(flag_wr), .flag_wdata_i(bus_wdata[1:0]),
    .clr_done_i(clr_done), .zero_pulse_i(zero_o), .match_pulse_i(match_o),
    .stage_en_o(stage_en), .halt_o(halt), .mode_req_o(mode_req),
    .clr_req_o(clr_req), .sel_o(sel),
    .zero_flag_o(zero_flag), .match_flag_o(match_flag)
  );

  frt_count_core u_core (
    .clk(clk), .rst_n(rst_n), .step_i(step), .clr_req_i(clr_req),
    .mode_req_i(mode_req), .stage_en_i(stage_en), .lim_wr_i(lim_wr),
    .cnt_wr_i(cnt_wr), .wdata_i(bus_wdata),
    .cnt_o(cnt_o), .lim_o(lim), .dir_o(dir),
    .zero_pulse_o(zero_o), .match_pulse_o(match_o), .clr_done_o(clr_done)
  );

  assign stop_o   = halt;
  assign dir_up_o = (dir == FRT_DIR_UP);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      FRT_A_CTRL: begin
        bus_rdata[6]         = stage_en;
        bus_rdata[5]         = halt;
        bus_rdata[4]         = mode_req;
        bus_rdata[SEL_W-1:0] = sel;
      end
      FRT_A_DATA:  bus_rdata = cnt_o;
      FRT_A_LIMIT: bus_rdata = lim;
      default: begin
        bus_rdata[0] = zero_flag;
        bus_rdata[1] = match_flag;
      end
    endcase
  end
endmodule

// File: rtl/frt_timer_sva.sv
module frt_timer_sva
  import frt_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bus_we,
  input logic [1:0] bus_addr,
  input logic [1:0] wlow,
  input frt_word_t  bus_rdata,
  input frt_word_t  cnt_o,
  input logic       stop_o,
  input logic       zero_o,
  input logic       tick,
  input logic       clr_done,
  input logic       zero_flag
);
  logic data_wr;
  assign data_wr = bus_we && (bus_addr == 2'd1);

  // R7: halted counter holds unless loaded
  p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_o && !data_wr) |=> $stable(cnt_o));

  // R2: no movement without a prescaler tick
  p_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !data_wr) |=> $stable(cnt_o));

  // R3 / R4: one step moves by one or lands on zero
  p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !stop_o && !data_wr) |=>
      ((cnt_o == $past(cnt_o) + 16'd1) || (cnt_o == $past(cnt_o) - 16'd1) || (cnt_o == '0)));

  // R8: software clear never raises the zero event
  p_clr_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_done |=> !zero_o);

  // R10: zero event only with a zero count
  p_zero_evt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o |-> (cnt_o == '0));

  // R10: flag stays until cleared by a 0 write
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_flag && !(bus_we && bus_addr == 2'd3 && !wlow[0])) |=> zero_flag);

  // R8 / R11: clear bit and bit 7 read 0
  p_ctrl_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (bus_rdata[7] == 1'b0 && bus_rdata[3] == 1'b0));
endmodule

bind frt_timer frt_timer_sva u_sva (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .wlow(bus_wdata[1:0]), .bus_rdata(bus_rdata), .cnt_o(cnt_o),
  .stop_o(stop_o), .zero_o(zero_o), .tick(tick), .clr_done(clr_done),
  .zero_flag(zero_flag)
);

// File: tb/frt_timer_tb_top.sv
module frt_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata, cnt_o;
  logic        dir_up_o, stop_o, zero_o, match_o;

  always #5 clk = ~clk;

  frt_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_o(cnt_o),
    .dir_up_o(dir_up_o), .stop_o(stop_o), .zero_o(zero_o), .match_o(match_o)
  );

  int vectors = 0;
  int errors  = 0;
  bit finished = 1'b0;
  string phase = "R1";

  // Reference model state
  int m_cnt, m_lim, m_stg, m_presc, m_sel;
  bit m_up, m_act_tri, m_req_tri, m_stage, m_halt, m_clr;
  bit m_zf, m_mf, m_zp, m_mp;
  // scratch
  int n_cnt, n_lim, n_stg, span, lim_now;
  bit n_up, n_act, n_clr, n_zf, n_mf, n_zp, n_mp, stepping;

  function automatic int model_read(input int a);
    case (a)
      0: return (int'(m_stage) << 6) + (int'(m_halt) << 5) + (int'(m_req_tri) << 4) + m_sel;
      1: return m_cnt;
      2: return m_lim;
      default: return int'(m_zf) + (int'(m_mf) << 1);
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_lim = 65535; m_stg = 65535; m_presc = 0; m_sel = 0;
      m_up = 1; m_act_tri = 0; m_req_tri = 0; m_stage = 0; m_halt = 1; m_clr = 0;
      m_zf = 0; m_mf = 0; m_zp = 0; m_mp = 0;
    end else begin
      span = 1 << m_sel;
      stepping = ((m_presc % span) == span - 1) && !m_halt;
      n_zf = m_zf; n_mf = m_mf;
      if (bus_we && bus_addr == 3) begin
        if (!bus_wdata[0]) n_zf = 0;
        if (!bus_wdata[1]) n_mf = 0;
      end
      if (m_zp) n_zf = 1;
      if (m_mp) n_mf = 1;
      n_zp = 0; n_mp = 0;
      n_cnt = m_cnt; n_up = m_up; n_act = m_act_tri; n_lim = m_lim; n_stg = m_stg; n_clr = m_clr;
      if (bus_we && bus_addr == 1) begin
        n_cnt = bus_wdata;
      end else if (stepping && m_clr) begin
        n_cnt = 0; n_up = 1; n_clr = 0;
      end else if (stepping) begin
        if (m_cnt == 0) begin
          n_act = m_req_tri;
          if (m_stage) n_lim = m_stg;
        end
        lim_now = n_lim;
        n_mp = (m_cnt == lim_now);
        if (!n_act) begin
          n_up = 1;
          n_cnt = (m_cnt == lim_now) ? 0 : (m_cnt + 1) % 65536;
        end else begin
          if (m_cnt == 0) n_up = 1;
          else if (m_cnt == lim_now) n_up = 0;
          n_cnt = n_up ? (m_cnt + 1) % 65536 : m_cnt - 1;
        end
        n_zp = (n_cnt == 0);
      end
      if (bus_we && bus_addr == 2) begin
        n_stg = bus_wdata;
        if (!m_stage) n_lim = bus_wdata;
      end
      if (bus_we && bus_addr == 0) begin
        m_stage = bus_wdata[6]; m_halt = bus_wdata[5]; m_req_tri = bus_wdata[4];
        m_sel = bus_wdata[2:0];
        n_clr = bus_wdata[3] && !bus_wdata[5];
      end
      m_cnt = n_cnt; m_up = n_up; m_act_tri = n_act; m_lim = n_lim; m_stg = n_stg;
      m_clr = n_clr; m_zf = n_zf; m_mf = n_mf; m_zp = n_zp; m_mp = n_mp;
      m_presc = (m_presc + 1) % 128;
    end
  end

  task automatic note(input string req, input string what, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  // Compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      note(phase, "count", cnt_o, m_cnt);
      note(phase, "dir", dir_up_o, m_up);
      note(phase, "stop", stop_o, m_halt);
      note(phase, "zero event", zero_o, m_zp);
      note(phase, "match event", match_o, m_mp);
      note(phase, "read", bus_rdata, model_read(bus_addr));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); #1;
    bus_we = 1'b1; bus_addr = a[1:0]; bus_wdata = d[15:0];
    @(negedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_check(input string req, input int a, input int exp);
    @(negedge clk); #1;
    bus_addr = a[1:0];
    #1;
    note(req, "directed read", bus_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    idle(4);
    @(negedge clk); #1 rst_n = 1'b1;
    phase = "R1";
    rd_check("R1", 0, 16'h0020);
    rd_check("R1", 1, 16'h0000);
    rd_check("R1", 2, 16'hFFFF);
    rd_check("R1", 3, 16'h0000);
    phase = "R11";
    wr(0, 16'h00A0);
    rd_check("R11", 0, 16'h0020);
    phase = "R3";
    wr(2, 5);
    wr(0, 16'h0000);
    idle(20);
    phase = "R2";
    wr(0, 16'h0002);
    idle(40);
    phase = "R10";
    wr(0, 16'h0022);
    idle(3);
    rd_check("R10", 3, 3);
    wr(3, 16'h0002);
    rd_check("R10", 3, 2);
    wr(3, 16'h0000);
    rd_check("R10", 3, 0);
    phase = "R5";
    wr(1, 3);
    wr(0, 16'h0010);
    rd_check("R5", 0, 16'h0010);
    idle(6);
    phase = "R4";
    idle(30);
    phase = "R6";
    wr(0, 16'h0050);
    wr(2, 9);
    rd_check("R6", 2, 5);
    idle(40);
    rd_check("R6", 2, 9);
    wr(0, 16'h0040);
    wr(2, 7);
    rd_check("R6", 2, 9);
    wr(0, 16'h0000);
    wr(2, 7);
    rd_check("R6", 2, 7);
    phase = "R9";
    wr(1, 16'hFFF0);
    idle(25);
    phase = "R7";
    wr(0, 16'h0020);
    idle(10);
    note("R7", "stop held", stop_o, 1);
    phase = "R8";
    wr(0, 16'h0028);
    rd_check("R8", 0, 16'h0020);
    wr(0, 16'h0000);
    idle(12);
    phase = "R9";
    wr(0, 16'h0020);
    wr(1, 0);
    rd_check("R9", 1, 0);
    wr(1, 16'h0004);
    rd_check("R9", 1, 4);
    phase = "R8";
    wr(0, 16'h0003);
    idle(5);
    wr(0, 16'h000B);
    idle(20);
    wr(0, 16'h0007);
    idle(30);
    wr(0, 16'h000F);
    wr(0, 16'h0007);
    idle(300);
    wr(0, 16'h001F);
    idle(300);
    phase = "R2";
    wr(0, 16'h0001);
    idle(40);
    @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule